// File: doc/BRIEF.md
# Capacity Slice Reservation and Mask Remapper

This block sits inside a shared-cache capacity controller that is reached through several QoS register interfaces, each named by a QRID. For every interface it carries out the one-time reservation operation. The operation claims a contiguous slice of the physical capacity blocks. The block checks the requested block mask and reports a status code. It also reports for every interface how many capacity blocks that interface can allocate.

After a reservation, a domain describes its allocation for an RCID with a compact mask. Bit 0 of that mask stands for the lowest block of its slice. A combinational lookup port takes a QRID and a compact mask and returns the physical block mask. Before any reservation, an interface sees all blocks, and the lookup passes the mask through unchanged. Reservation state is cleared only by reset.

Top module: `qos_cap_remap`

## Requirements
- R1: After reset, `status` is 0, every per-interface count is NBLK, and the lookup returns the compact mask unchanged for every interface.
- R2: A request with `op_code` equal to 4 and a mask that is one nonzero contiguous run of ones, on an interface not yet reserved, sets `status` to 1 on the next clock. That interface's count becomes the number of ones in the mask.
- R3: A request with opcode 4 and a mask that is zero or holds more than one run of ones, on an unreserved interface, sets `status` to 5. It changes no count and no mapping, and the interface stays unreserved.
- R4: A request with opcode 4 on an interface that was already reserved since reset sets `status` to 2 whatever its mask, and changes no count or mapping.
- R5: A request with any opcode other than 4 has no effect on `status`, on the counts or on the lookup.
- R6: `status` keeps its value in every cycle without a request.
- R7: For a reserved interface with count C whose lowest reserved block is B, compact bit i with i < C drives physical bit B+i. Compact bits at C and above are dropped.
- R8: A reservation on one interface leaves the counts and mappings of every other interface unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request strobe, one cycle per request |
| op_qrid | input | QW | Interface addressed by the request |
| op_code | input | OPW | Operation code, 4 = reserve |
| op_mask | input | NBLK | Requested physical block mask |
| status | output | 3 | Result of the last request: 0 none, 1 done, 2 already reserved, 5 bad mask |
| blk_cnt | output | NQRI*CW | Usable block count per interface, interface q in bits [q*CW +: CW] |
| lk_qrid | input | QW | Interface for the mask lookup |
| lk_mask | input | NBLK | Compact mask as programmed by the domain |
| lk_phys | output | NBLK | Physical block mask |

## Verification
A wrong base index or count inside the block shows at once on the lookup port. The bench sweeps every compact mask for every interface after each change of state, so a slice that is shifted or cut short produces a mismatch. A reservation that is wrongly accepted or wrongly rejected shows in `status` one clock after the request. It also shows in that interface's count, and then as a second-request status on a later attempt. Leaks between interfaces show in the counts and mappings of the interfaces that were not addressed.

// File: rtl/qos_cap_remap.sv
module qos_cap_remap #(
  parameter int NBLK = 8,
  parameter int NQRI = 4,
  parameter int OPW  = 4,
  localparam int QW  = (NQRI > 1) ? $clog2(NQRI) : 1,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW  = $clog2(NBLK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [QW-1:0]        op_qrid,
  input  logic [OPW-1:0]       op_code,
  input  logic [NBLK-1:0]      op_mask,
  output logic [2:0]           status,
  output logic [NQRI*CW-1:0]   blk_cnt,
  input  logic [QW-1:0]        lk_qrid,
  input  logic [NBLK-1:0]      lk_mask,
  output logic [NBLK-1:0]      lk_phys
);
  localparam logic [OPW-1:0] OP_RESV = OPW'(4);
  localparam logic [2:0] ST_OK = 3'd1, ST_AGAIN = 3'd2, ST_BADMASK = 3'd5;

  logic [NQRI-1:0] resv;
  logic [BW-1:0]   base_q [NQRI];
  logic [CW-1:0]   cnt_q  [NQRI];

  logic [NBLK-1:0] low_bit;
  logic            contig;
  logic [BW-1:0]   lo_idx;
  logic [CW-1:0]   pop;

  assign low_bit = op_mask & (~op_mask + NBLK'(1));
  assign contig  = (|op_mask) && (((op_mask + low_bit) & op_mask) == '0);

  always_comb begin
    lo_idx = '0;
    pop    = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (op_mask[i]) begin
        lo_idx = BW'(i);
        pop    = pop + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      resv   <= '0;
      for (int q = 0; q < NQRI; q++) begin
        base_q[q] <= '0;
        cnt_q[q]  <= CW'(NBLK);
      end
    end else if (op_valid && op_code == OP_RESV) begin
      if (resv[op_qrid]) begin
        status <= ST_AGAIN;
      end else if (!contig) begin
        status <= ST_BADMASK;
      end else begin
        status          <= ST_OK;
        resv[op_qrid]   <= 1'b1;
        base_q[op_qrid] <= lo_idx;
        cnt_q[op_qrid]  <= pop;
      end
    end
  end

  for (genvar q = 0; q < NQRI; q++) begin : g_cnt
    assign blk_cnt[q*CW +: CW] = cnt_q[q];
  end

  logic [NBLK-1:0] keep;
  assign keep    = ~({NBLK{1'b1}} << cnt_q[lk_qrid]);
  assign lk_phys = (lk_mask & keep) << base_q[lk_qrid];
endmodule

// File: rtl/qos_cap_remap_chk.sv
module qos_cap_remap_chk #(
  parameter int NBLK = 8,
  parameter int NQRI = 4,
  parameter int OPW  = 4,
  localparam int CW  = $clog2(NBLK + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [OPW-1:0]     op_code,
  input logic [2:0]         status,
  input logic [NQRI*CW-1:0] blk_cnt,
  input logic [NBLK-1:0]    lk_mask,
  input logic [NBLK-1:0]    lk_phys
);
  a_r2_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd0 || status == 3'd1 || status == 3'd2 || status == 3'd5);

  a_r6_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status));

  a_r4_fail_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPW'(4)) |=> (status == 3'd1 || $stable(blk_cnt)));

  a_r5_other_op: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != OPW'(4)) |=> ($stable(blk_cnt) && $stable(status)));

  a_r7_no_extra_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lk_phys) <= $countones(lk_mask));

  for (genvar q = 0; q < NQRI; q++) begin : g_cnt_chk
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      blk_cnt[q*CW +: CW] != '0 && blk_cnt[q*CW +: CW] <= CW'(NBLK));
  end
endmodule

bind qos_cap_remap qos_cap_remap_chk #(.NBLK(NBLK), .NQRI(NQRI), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .status(status), .blk_cnt(blk_cnt), .lk_mask(lk_mask), .lk_phys(lk_phys));

// File: tb/test_qos_cap_remap.sv
`timescale 1ns/1ps
module test_qos_cap_remap;
  localparam int NBLK = 8, NQRI = 4, OPW = 4, QW = 2, CW = 4;

  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [QW-1:0] op_qrid = '0, lk_qrid = '0;
  logic [OPW-1:0] op_code = '0;
  logic [NBLK-1:0] op_mask = '0, lk_mask = '0, lk_phys;
  logic [2:0] status;
  logic [NQRI*CW-1:0] blk_cnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_base [NQRI];
  int m_cnt  [NQRI];

  always #5 clk = ~clk;

  qos_cap_remap #(.NBLK(NBLK), .NQRI(NQRI), .OPW(OPW)) i_qos_cap_remap (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_qrid(op_qrid),
    .op_code(op_code), .op_mask(op_mask), .status(status), .blk_cnt(blk_cnt),
    .lk_qrid(lk_qrid), .lk_mask(lk_mask), .lk_phys(lk_phys));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int runs(int m);
    int r = 0;
    for (int i = 0; i < NBLK; i++)
      if (m[i] && (i == 0 || !m[i-1])) r++;
    return r;
  endfunction

  function automatic int ones(int m);
    int c = 0;
    for (int i = 0; i < NBLK; i++) c += m[i];
    return c;
  endfunction

  function automatic int lowest(int m);
    for (int i = 0; i < NBLK; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic do_op(int q, int code, int m);
    @(negedge clk);
    op_valid = 1; op_qrid = QW'(q); op_code = OPW'(code); op_mask = NBLK'(m);
    @(negedge clk);
    op_valid = 0; op_mask = '0; op_code = '0;
  endtask

  task automatic check_counts(string req);
    for (int q = 0; q < NQRI; q++)
      check(req, int'(blk_cnt[q*CW +: CW]), m_cnt[q]);
  endtask

  task automatic sweep_lookup(string req);
    for (int q = 0; q < NQRI; q++)
      for (int m = 0; m < (1 << NBLK); m++) begin
        int exp = 0;
        lk_qrid = QW'(q); lk_mask = NBLK'(m);
        #1;
        for (int i = 0; i < NBLK; i++)
          if (i < m_cnt[q] && m[i]) exp |= (1 << (m_base[q] + i));
        check(req, int'(lk_phys), exp);
      end
  endtask

  task automatic model_reset();
    for (int q = 0; q < NQRI; q++) begin m_base[q] = 0; m_cnt[q] = NBLK; end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", int'(status), 0);
    check_counts("R1 count");
    sweep_lookup("R1 lookup");

    // R3 every empty or split mask on interface 3 is rejected
    for (int m = 0; m < (1 << NBLK); m++)
      if (runs(m) != 1) begin
        do_op(3, 4, m);
        check("R3 status", int'(status), 5);
        check("R3 count", int'(blk_cnt[3*CW +: CW]), NBLK);
      end
    sweep_lookup("R3 lookup");

    // R2 reserve blocks 7:6 on interface 0, R8 others stay
    do_op(0, 4, 8'hC0);
    check("R2 status", int'(status), 1);
    m_base[0] = lowest(8'hC0); m_cnt[0] = ones(8'hC0);
    check_counts("R8 count");
    // R6 status held
    repeat (4) @(negedge clk);
    check("R6 status hold", int'(status), 1);

    // R4 second request, legal and illegal mask
    do_op(0, 4, 8'h01);
    check("R4 status", int'(status), 2);
    do_op(0, 4, 8'h05);
    check("R4 status bad mask", int'(status), 2);
    check_counts("R4 count");

    // R5 other opcodes do nothing
    for (int c = 0; c < 16; c++)
      if (c != 4) begin
        do_op(1, c, 8'h0F);
        check("R5 status", int'(status), 2);
        check_counts("R5 count");
      end

    do_op(1, 4, 8'h3F);
    check("R2 status q1", int'(status), 1);
    m_base[1] = 0; m_cnt[1] = 6;
    do_op(2, 4, 8'h18);
    check("R2 status q2", int'(status), 1);
    m_base[2] = 3; m_cnt[2] = 2;
    do_op(3, 4, 8'hFF);
    check("R2 status q3 full", int'(status), 1);
    m_base[3] = 0; m_cnt[3] = 8;
    check_counts("R2 count");
    sweep_lookup("R7 lookup");

    // R1 reset clears reservations
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    model_reset();
    check("R1 status after reset", int'(status), 0);
    check_counts("R1 count after reset");
    do_op(0, 4, 8'h80);
    check("R2 status after reset", int'(status), 1);
    m_base[0] = 7; m_cnt[0] = 1;
    check_counts("R2 count single");
    sweep_lookup("R7 lookup single");

    finish_run();
  end
endmodule